// File: doc/BRIEF.md
# Branch and Call Resolution Unit

This unit resolves control-transfer instructions for a 32-bit RISC core. Each cycle it takes a valid flag, an instruction word, the PC of that instruction, the values of the instruction's offset register and destination register, and the zero and carry flags. One cycle later it reports whether the branch is taken, the PC to fetch next, and up to two register writebacks. The first writeback is the link written by a call. The second is the updated offset register when the instruction asks for a post-modify.

Two instruction classes are resolved. The unconditional class covers four forms: an absolute jump, a relative jump, a call that stores a link, and a return through a register. The conditional class covers four relative jumps, each tested on one flag. A relative offset is either a signed 15-bit immediate or the full value of a second source register. When the offset comes from a register, that register may be stepped up or down after use. All other instruction classes pass through the unit as sequential flow.

Top module: `branch_resolve`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs `out_valid`, `taken`, `link_we` and `pm_we` are 0 after that edge, and `target`, `link_val` and `pm_val` are 0.
- R2: Absolute jump (instr[31:28]=2, instr[27:26]=0): taken=1, and target is {pc[31:26], instr[25:0]}.
- R3: Relative jump (instr[31:28]=2, instr[27:26]=1): taken=1, and target is pc plus the offset.
- R4: Offset selection uses instr[25]. When it is 0, the offset is instr[24:10] as a signed 15-bit value extended to 32 bits. When it is 1, the offset is the `src2_val` input, whose register number is instr[14:10].
- R5: Call (instr[31:28]=2, instr[27:26]=2): taken=1 and target is pc plus the offset. Also link_we=1, link_idx=instr[4:0] and link_val=pc+1.
- R6: Return (instr[31:28]=2, instr[27:26]=3): taken=1, target equals `dst_val`, and link_we=0.
- R7: Conditional jump (instr[31:28]=3): instr[27:26] picks the condition. 0 means zero set, 1 means zero clear, 2 means carry set and 3 means carry clear. When the condition holds, taken=1 and target is pc plus the offset.
- R8: A conditional jump whose condition fails gives taken=0, target=pc+1 and link_we=0.
- R9: Post-modify applies to an instruction of either class with instr[25]=1. instr[24] gives the direction (1 means subtract) and instr[23:22] gives the step: 0, 1, 2 or 4 for codes 0 to 3. A nonzero step gives pm_we=1, pm_idx=instr[14:10] and pm_val=src2_val plus or minus the step. The offset used for the jump is the value before the step. A zero step gives pm_we=0. Post-modify happens whether or not a conditional jump is taken.
- R10: Any other value of instr[31:28] gives taken=0, target=pc+1, link_we=0 and pm_we=0.
- R11: All results appear exactly one clock after the inputs are sampled. out_valid equals in_valid from the previous cycle. When out_valid is 0, taken, link_we and pm_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | PC of the instruction |
| src2_val | input | 32 | Value of offset register instr[14:10] |
| dst_val | input | 32 | Value of register instr[4:0] |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Control transfer taken |
| target | output | 32 | Next PC |
| link_we | output | 1 | Link write enable |
| link_idx | output | 5 | Link register number |
| link_val | output | 32 | Link value (return address) |
| pm_we | output | 1 | Offset register write enable |
| pm_idx | output | 5 | Offset register number |
| pm_val | output | 32 | Stepped offset register value |

## Verification
The assertions check the following on every cycle:
- out_valid follows in_valid with a one-cycle delay.
- An invalid output slot raises no strobe.
- A link write only happens together with a taken branch.
- Every not-taken result points at the sequential PC.
- A post-modify writes the offset register number that was decoded.

The directed scenarios cover the rest, because these depend on the instruction encoding:
- the actual target arithmetic for each form;
- sign extension of negative immediates;
- each flag condition in both its holding and failing case;
- the step sizes and directions;
- the pass-through of non-branch classes.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;

    // Instruction field layout (decoded positions are behavioural)
    localparam int CLS_HI   = 31;
    localparam int CLS_LO   = 28;
    localparam int TYP_HI   = 27;
    localparam int TYP_LO   = 26;
    localparam int OSEL_BIT = 25;
    localparam int ABS_W    = 26;
    localparam int IMM_HI   = 24;
    localparam int IMM_LO   = 10;
    localparam int IMM_W    = IMM_HI - IMM_LO + 1;
    localparam int DIR_BIT  = 24;
    localparam int AMT_HI   = 23;
    localparam int AMT_LO   = 22;
    localparam int RIDX_W   = 5;
    localparam int S2_LO    = 10;
    localparam int DST_LO   = 0;

    localparam logic [3:0] CLASS_UNCOND = 4'd2;
    localparam logic [3:0] CLASS_COND   = 4'd3;

    typedef enum logic [3:0] {
        K_NONE,
        K_ABS,
        K_REL,
        K_CALL,
        K_RET,
        K_JZ,
        K_JNZ,
        K_JC,
        K_JNC
    } br_kind_e;

    typedef struct packed {
        br_kind_e            kind;
        logic                off_reg;
        logic                step_neg;
        logic [1:0]          step_code;
        logic [RIDX_W-1:0]   src2_idx;
        logic [RIDX_W-1:0]   dst_idx;
        logic [ABS_W-1:0]    abs_field;
        logic [IMM_W-1:0]    imm;
    } br_dec_t;

    function automatic logic [2:0] step_of(input logic [1:0] code);
        case (code)
            2'd0:    step_of = 3'd0;
            2'd1:    step_of = 3'd1;
            2'd2:    step_of = 3'd2;
            default: step_of = 3'd4;
        endcase
    endfunction

    function automatic logic is_cond(input br_kind_e k);
        is_cond = (k == K_JZ) || (k == K_JNZ) || (k == K_JC) || (k == K_JNC);
    endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode
    import branch_resolve_pkg::*;
(
    input  logic [31:0] instr,
    output br_dec_t     dec
);
    logic [3:0] cls;
    logic [1:0] typ;

    assign cls = instr[CLS_HI:CLS_LO];
    assign typ = instr[TYP_HI:TYP_LO];

    always_comb begin
        dec           = '0;
        dec.kind      = K_NONE;
        dec.off_reg   = instr[OSEL_BIT];
        dec.step_neg  = instr[DIR_BIT];
        dec.step_code = instr[AMT_HI:AMT_LO];
        dec.src2_idx  = instr[S2_LO +: RIDX_W];
        dec.dst_idx   = instr[DST_LO +: RIDX_W];
        dec.abs_field = instr[ABS_W-1:0];
        dec.imm       = instr[IMM_HI:IMM_LO];
        if (cls == CLASS_UNCOND) begin
            case (typ)
                2'd0:    dec.kind = K_ABS;
                2'd1:    dec.kind = K_REL;
                2'd2:    dec.kind = K_CALL;
                default: dec.kind = K_RET;
            endcase
        end else if (cls == CLASS_COND) begin
            case (typ)
                2'd0:    dec.kind = K_JZ;
                2'd1:    dec.kind = K_JNZ;
                2'd2:    dec.kind = K_JC;
                default: dec.kind = K_JNC;
            endcase
        end
    end
endmodule

// File: rtl/br_cond.sv
module br_cond
    import branch_resolve_pkg::*;
(
    input  br_kind_e kind,
    input  logic     flag_z,
    input  logic     flag_c,
    output logic     pass
);
    always_comb begin
        case (kind)
            K_JZ:    pass = flag_z;
            K_JNZ:   pass = !flag_z;
            K_JC:    pass = flag_c;
            K_JNC:   pass = !flag_c;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
module br_target
    import branch_resolve_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_dec_t          dec,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  src2_val,
    input  logic [XLEN-1:0]  dst_val,
    input  logic             cond_pass,
    output logic             taken,
    output logic [XLEN-1:0]  target,
    output logic             link_we,
    output logic [XLEN-1:0]  link_val,
    output logic             pm_we,
    output logic [XLEN-1:0]  pm_val
);
    localparam int EXT_W = XLEN - IMM_W;
    localparam int UP_W  = XLEN - ABS_W;

    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] rel_pc;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] step;

    assign offset   = dec.off_reg ? src2_val : {{EXT_W{dec.imm[IMM_W-1]}}, dec.imm};
    assign rel_pc   = pc + offset;
    assign seq_pc   = pc + XLEN'(1);
    assign link_val = seq_pc;
    assign step     = XLEN'(step_of(dec.step_code));

    always_comb begin
        taken   = 1'b0;
        target  = seq_pc;
        link_we = 1'b0;
        case (dec.kind)
            K_ABS: begin
                taken  = 1'b1;
                target = {pc[XLEN-1 -: UP_W], dec.abs_field};
            end
            K_REL: begin
                taken  = 1'b1;
                target = rel_pc;
            end
            K_CALL: begin
                taken   = 1'b1;
                target  = rel_pc;
                link_we = 1'b1;
            end
            K_RET: begin
                taken  = 1'b1;
                target = dst_val;
            end
            default: begin
                if (is_cond(dec.kind) && cond_pass) begin
                    taken  = 1'b1;
                    target = rel_pc;
                end
            end
        endcase
    end

    assign pm_we  = (dec.kind != K_NONE) && dec.off_reg && (step != '0);
    assign pm_val = dec.step_neg ? (src2_val - step) : (src2_val + step);
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import branch_resolve_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [31:0]         instr,
    input  logic [XLEN-1:0]     pc,
    input  logic [XLEN-1:0]     src2_val,
    input  logic [XLEN-1:0]     dst_val,
    input  logic                flag_z,
    input  logic                flag_c,
    output logic                out_valid,
    output logic                taken,
    output logic [XLEN-1:0]     target,
    output logic                link_we,
    output logic [RIDX_W-1:0]   link_idx,
    output logic [XLEN-1:0]     link_val,
    output logic                pm_we,
    output logic [RIDX_W-1:0]   pm_idx,
    output logic [XLEN-1:0]     pm_val
);
    br_dec_t         dec;
    logic            pass;
    logic            c_taken, c_link_we, c_pm_we;
    logic [XLEN-1:0] c_target, c_link_val, c_pm_val;

    br_decode u_dec (.instr(instr), .dec(dec));

    br_cond u_cond (
        .kind(dec.kind), .flag_z(flag_z), .flag_c(flag_c), .pass(pass)
    );

    br_target #(.XLEN(XLEN)) u_tgt (
        .dec(dec), .pc(pc), .src2_val(src2_val), .dst_val(dst_val),
        .cond_pass(pass), .taken(c_taken), .target(c_target),
        .link_we(c_link_we), .link_val(c_link_val),
        .pm_we(c_pm_we), .pm_val(c_pm_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            target    <= '0;
            link_we   <= 1'b0;
            link_idx  <= '0;
            link_val  <= '0;
            pm_we     <= 1'b0;
            pm_idx    <= '0;
            pm_val    <= '0;
        end else begin
            out_valid <= in_valid;
            taken     <= in_valid && c_taken;
            target    <= c_target;
            link_we   <= in_valid && c_link_we;
            link_idx  <= dec.dst_idx;
            link_val  <= c_link_val;
            pm_we     <= in_valid && c_pm_we;
            pm_idx    <= dec.src2_idx;
            pm_val    <= c_pm_val;
        end
    end

    // R11: output valid tracks input valid one cycle later
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!taken && !link_we && !pm_we));
    // R5: a link is only written by a taken transfer
    a_r5_link_needs_taken: assert property (@(posedge clk) disable iff (rst)
        link_we |-> taken);
    // R8: not-taken resolves to the sequential address
    a_r8_fall_through: assert property (@(posedge clk) disable iff (rst)
        in_valid && !c_taken |=> (target == $past(pc) + XLEN'(1)));
    // R9: post-modify targets the decoded offset register
    a_r9_pm_index: assert property (@(posedge clk) disable iff (rst)
        in_valid && c_pm_we |=> (pm_we && pm_idx == $past(instr[S2_LO +: RIDX_W])));
endmodule

// File: tb/branch_resolve_tb.sv
module branch_resolve_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr, pc, src2_val, dst_val;
    logic        flag_z, flag_c;
    logic        out_valid, taken, link_we, pm_we;
    logic [31:0] target, link_val, pm_val;
    logic [4:0]  link_idx, pm_idx;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    branch_resolve u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .pc(pc),
        .src2_val(src2_val), .dst_val(dst_val), .flag_z(flag_z), .flag_c(flag_c),
        .out_valid(out_valid), .taken(taken), .target(target),
        .link_we(link_we), .link_idx(link_idx), .link_val(link_val),
        .pm_we(pm_we), .pm_idx(pm_idx), .pm_val(pm_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_imm(input logic [3:0] cls, input logic [1:0] typ,
                                           input logic [14:0] imm, input logic [4:0] dst);
        return {cls, typ, 1'b0, imm, 5'd0, dst};
    endfunction

    function automatic logic [31:0] mk_reg(input logic [3:0] cls, input logic [1:0] typ,
                                           input logic [2:0] code, input logic [4:0] s2,
                                           input logic [4:0] dst);
        return {cls, typ, 1'b1, code, 7'd0, s2, 5'd0, dst};
    endfunction

    function automatic logic [31:0] sx15(input logic [14:0] v);
        return 32'($signed(v));
    endfunction

    task automatic issue(input logic [31:0] ins, input logic [31:0] p, input logic [31:0] s2,
                         input logic [31:0] dv, input logic z, input logic c);
        in_valid = 1'b1; instr = ins; pc = p; src2_val = s2; dst_val = dv;
        flag_z = z; flag_c = c;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 taken", 32'(taken), 0);
        chk("R1 target", target, 0);
        chk("R1 link_we", 32'(link_we), 0);
        chk("R1 pm_we", 32'(pm_we), 0);
        chk("R1 pm_val", pm_val, 0);
    endtask

    task automatic t_abs;
        logic [31:0] p = 32'hA400_0010;
        issue(mk_imm(4'd2, 2'd0, 15'h0, 5'd0) | 32'h0123_4567, p, 0, 0, 0, 0);
        chk("R2 taken", 32'(taken), 1);
        chk("R2 target", target, {p[31:26], 26'h123_4567});
        chk("R11 out_valid", 32'(out_valid), 1);
    endtask

    task automatic t_rel;
        issue(mk_imm(4'd2, 2'd1, 15'h7FFC, 5'd0), 32'd100, 0, 0, 0, 0);
        chk("R3 taken", 32'(taken), 1);
        chk("R4 negative imm", target, 32'd100 + sx15(15'h7FFC));
        issue(mk_imm(4'd2, 2'd1, 15'h0123, 5'd0), 32'h1000, 0, 0, 0, 0);
        chk("R4 positive imm", target, 32'h1123);
        issue(mk_reg(4'd2, 2'd1, 3'b000, 5'd7, 5'd0), 32'h2000, 32'hFFFF_FF00, 0, 0, 0);
        chk("R4 register offset", target, 32'h1F00);
        chk("R9 zero step", 32'(pm_we), 0);
    endtask

    task automatic t_call;
        issue(mk_imm(4'd2, 2'd2, 15'h0040, 5'd31), 32'h300, 0, 0, 0, 0);
        chk("R5 target", target, 32'h340);
        chk("R5 link_we", 32'(link_we), 1);
        chk("R5 link_idx", 32'(link_idx), 31);
        chk("R5 link_val", link_val, 32'h301);
    endtask

    task automatic t_ret;
        issue(mk_imm(4'd2, 2'd3, 15'h0, 5'd9), 32'h500, 0, 32'hDEAD_BEE0, 0, 0);
        chk("R6 taken", 32'(taken), 1);
        chk("R6 target", target, 32'hDEAD_BEE0);
        chk("R6 link_we", 32'(link_we), 0);
    endtask

    task automatic t_cond;
        for (int t = 0; t < 4; t++) begin
            for (int f = 0; f < 2; f++) begin
                logic z, c, hold;
                z = (t < 2) ? f[0] : 1'b0;
                c = (t >= 2) ? f[0] : 1'b0;
                hold = (t == 0) ? z : (t == 1) ? !z : (t == 2) ? c : !c;
                issue(mk_imm(4'd3, t[1:0], 15'h0010, 5'd0), 32'h800, 0, 0, z, c);
                chk(hold ? "R7 taken" : "R8 taken", 32'(taken), 32'(hold));
                chk(hold ? "R7 target" : "R8 target", target, hold ? 32'h810 : 32'h801);
                chk("R8 link_we", 32'(link_we), 0);
            end
        end
    endtask

    task automatic t_postmod;
        issue(mk_reg(4'd2, 2'd1, 3'b011, 5'd12, 5'd0), 32'h40, 32'h20, 0, 0, 0);
        chk("R9 offset pre-step", target, 32'h60);
        chk("R9 pm_we", 32'(pm_we), 1);
        chk("R9 pm_idx", 32'(pm_idx), 12);
        chk("R9 +4", pm_val, 32'h24);
        issue(mk_reg(4'd3, 2'd0, 3'b110, 5'd3, 5'd0), 32'h40, 32'h20, 0, 0, 0);
        chk("R9 untaken cond", 32'(taken), 0);
        chk("R9 -2 on untaken", pm_val, 32'h1E);
        chk("R9 pm_we untaken", 32'(pm_we), 1);
        issue(mk_reg(4'd2, 2'd1, 3'b101, 5'd3, 5'd0), 32'h40, 32'h0, 0, 0, 0);
        chk("R9 -1 wrap", pm_val, 32'hFFFF_FFFF);
    endtask

    task automatic t_other;
        issue(mk_reg(4'd4, 2'd2, 3'b011, 5'd3, 5'd1), 32'h77, 32'h5, 32'h9, 1, 1);
        chk("R10 taken", 32'(taken), 0);
        chk("R10 target", target, 32'h78);
        chk("R10 link_we", 32'(link_we), 0);
        chk("R10 pm_we", 32'(pm_we), 0);
        @(posedge clk); @(negedge clk);
        chk("R11 idle valid", 32'(out_valid), 0);
        chk("R11 idle taken", 32'(taken), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; instr = mk_imm(4'd2, 2'd1, 15'h5, 5'd0);
        pc = 0; src2_val = 0; dst_val = 0; flag_z = 0; flag_c = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        t_abs();
        t_rel();
        t_call();
        t_ret();
        t_cond();
        t_postmod();
        t_other();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule